// File: doc/BRIEF.md
# Test Access Port Sequencer

This block is the state machine of a boundary-scan test access port. It runs on the test clock, advances on every rising edge according to the test-mode-select input, and drops straight into its reset state whenever the active-low test reset is pulled low, with no clock needed.

The block does not keep two copies of the six scan phases. Capture, shift, first exit, pause, second exit and update are stored once. Two branch flags record whether the phase states currently belong to the data-register scan or the instruction-register scan.

Surrounding logic reads four things from the block: the registered state, the state it will take on the next edge, the two branch flags, and four decoded strobes. The strobes mark test-logic reset and the data-register capture, shift and update phases. Instruction and data registers, serial output selection and boundary cells are built elsewhere around these outputs.

Top module: `tap_sequencer`

## Requirements
- R1: While `trstN` is low, `curState` is 0 (test-logic reset), both branch flags are 0 and `inReset` is 1, with no clock edge needed.
- R2: State codes on `curState`/`nxtState` are: 0 reset, 1 idle, 2 select-DR, 3 capture, 4 shift, 5 exit1, 6 pause, 7 exit2, 8 update, 9 select-IR. Reset goes to idle on tms=0 and stays on tms=1. Idle stays on tms=0 and goes to select-DR on tms=1.
- R3: Select-DR with tms=0 enters capture with `drActive`=1 and `irActive`=0. With tms=1 it moves to select-IR.
- R4: Select-IR with tms=0 enters capture with `irActive`=1 and `drActive`=0. With tms=1 it returns to reset.
- R5: Within the phase states, the transitions are:
  - Capture goes to shift on tms=0 and to exit1 on tms=1.
  - Shift holds on tms=0 and goes to exit1 on tms=1.
  - Exit1 goes to pause on tms=0 and to update on tms=1.
  - Pause holds on tms=0 and goes to exit2 on tms=1.
  - Exit2 goes back to shift on tms=0 and to update on tms=1.
- R6: Update goes to select-DR on tms=1 and to idle on tms=0.
- R7: The branch flags are never both 1. Both are 0 in reset, idle, select-DR and select-IR. Neither changes while moving between phase states.
- R8: `nxtState` always equals the value `curState` takes after the next rising edge, given the present `tmsIn`.
- R9: `inReset` is 1 exactly in state 0. `drCapture`, `drShift` and `drUpdate` are 1 exactly in capture, shift and update respectively, and only while `drActive` is 1.
- R10: Five consecutive edges with tms=1 bring the machine to reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge active |
| trstN | input | 1 | Asynchronous active-low test reset |
| tmsIn | input | 1 | Test mode select |
| curState | output | 4 | Registered state code |
| nxtState | output | 4 | State code after the next edge |
| drActive | output | 1 | Phase states belong to the data-register scan |
| irActive | output | 1 | Phase states belong to the instruction-register scan |
| inReset | output | 1 | In test-logic reset |
| drCapture | output | 1 | In data-register capture |
| drShift | output | 1 | In data-register shift |
| drUpdate | output | 1 | In data-register update |

## Verification
A wrong transition appears on `curState` one edge after the offending tms value. It appears on `nxtState` in the same cycle, before any edge. A branch flag that is set wrongly or left standing shows at once on the flag ports and on the DR strobes, and it keeps showing for the rest of that scan. For that reason the reference model compares every output after every edge. It walks both scan branches through every phase loop and every exit. From each of the ten states it drives five tms-high edges, and it also pulls reset between clock edges.

// File: rtl/tap_seq_pkg.sv
package tap_seq_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    PH_RESET   = 4'd0,
    PH_IDLE    = 4'd1,
    PH_SELDR   = 4'd2,
    PH_CAPTURE = 4'd3,
    PH_SHIFT   = 4'd4,
    PH_EXIT1   = 4'd5,
    PH_PAUSE   = 4'd6,
    PH_EXIT2   = 4'd7,
    PH_UPDATE  = 4'd8,
    PH_SELIR   = 4'd9
  } tapPhase_e;

  // strobes from the sequencing control to the branch register
  typedef struct packed {
    logic enterDr;
    logic enterIr;
    logic leavePhase;
  } branchCtl_t;

endpackage

// File: rtl/tap_seq_ctrl.sv
module tap_seq_ctrl
  import tap_seq_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tmsIn,
  output tapPhase_e  stateQ,
  output tapPhase_e  stateD,
  output branchCtl_t ctl
);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      PH_RESET:   stateD = tmsIn ? PH_RESET  : PH_IDLE;
      PH_IDLE:    stateD = tmsIn ? PH_SELDR  : PH_IDLE;
      PH_SELDR:   stateD = tmsIn ? PH_SELIR  : PH_CAPTURE;
      PH_SELIR:   stateD = tmsIn ? PH_RESET  : PH_CAPTURE;
      PH_CAPTURE: stateD = tmsIn ? PH_EXIT1  : PH_SHIFT;
      PH_SHIFT:   stateD = tmsIn ? PH_EXIT1  : PH_SHIFT;
      PH_EXIT1:   stateD = tmsIn ? PH_UPDATE : PH_PAUSE;
      PH_PAUSE:   stateD = tmsIn ? PH_EXIT2  : PH_PAUSE;
      PH_EXIT2:   stateD = tmsIn ? PH_UPDATE : PH_SHIFT;
      PH_UPDATE:  stateD = tmsIn ? PH_SELDR  : PH_IDLE;
      default:    stateD = PH_RESET;
    endcase
  end

  always_comb begin
    ctl.enterDr    = (stateQ == PH_SELDR) && !tmsIn;
    ctl.enterIr    = (stateQ == PH_SELIR) && !tmsIn;
    ctl.leavePhase = (stateQ == PH_UPDATE);
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateQ <= PH_RESET;
    else        stateQ <= stateD;
  end

endmodule

// File: rtl/tap_seq_branch.sv
module tap_seq_branch
  import tap_seq_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  branchCtl_t ctl,
  input  tapPhase_e  stateQ,
  output logic       drActive,
  output logic       irActive,
  output logic       inReset,
  output logic       drCapture,
  output logic       drShift,
  output logic       drUpdate
);

  logic drQ, irQ;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      drQ <= 1'b0;
      irQ <= 1'b0;
    end else if (ctl.enterDr) begin
      drQ <= 1'b1;
      irQ <= 1'b0;
    end else if (ctl.enterIr) begin
      drQ <= 1'b0;
      irQ <= 1'b1;
    end else if (ctl.leavePhase) begin
      drQ <= 1'b0;
      irQ <= 1'b0;
    end
  end

  assign drActive  = drQ;
  assign irActive  = irQ;
  assign inReset   = (stateQ == PH_RESET);
  assign drCapture = drQ && (stateQ == PH_CAPTURE);
  assign drShift   = drQ && (stateQ == PH_SHIFT);
  assign drUpdate  = drQ && (stateQ == PH_UPDATE);

endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
  import tap_seq_pkg::*;
(
  input  logic               tck,
  input  logic               trstN,
  input  logic               tmsIn,
  output logic [STATE_W-1:0] curState,
  output logic [STATE_W-1:0] nxtState,
  output logic               drActive,
  output logic               irActive,
  output logic               inReset,
  output logic               drCapture,
  output logic               drShift,
  output logic               drUpdate
);

  tapPhase_e  stateQ, stateD;
  branchCtl_t ctl;

  tap_seq_ctrl i_ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .tmsIn  (tmsIn),
    .stateQ (stateQ),
    .stateD (stateD),
    .ctl    (ctl)
  );

  tap_seq_branch i_branch (
    .tck       (tck),
    .trstN     (trstN),
    .ctl       (ctl),
    .stateQ    (stateQ),
    .drActive  (drActive),
    .irActive  (irActive),
    .inReset   (inReset),
    .drCapture (drCapture),
    .drShift   (drShift),
    .drUpdate  (drUpdate)
  );

  assign curState = stateQ;
  assign nxtState = stateD;

endmodule

// File: rtl/tap_sequencer_chk.sv
module tap_sequencer_chk (
  input logic       tck,
  input logic       trstN,
  input logic       tmsIn,
  input logic [3:0] curState,
  input logic [3:0] nxtState,
  input logic       drActive,
  input logic       irActive
);

  logic inPhase;
  assign inPhase = (curState >= 4'd3) && (curState <= 4'd8);

  AST_FLAGS_EXCL: assert property (@(posedge tck) disable iff (!trstN)
    !(drActive && irActive)); // R7

  AST_FLAGS_IDLE: assert property (@(posedge tck) disable iff (!trstN)
    !inPhase |-> (!drActive && !irActive)); // R7

  AST_FLAGS_HELD: assert property (@(posedge tck) disable iff (!trstN)
    (inPhase && curState != 4'd3) |-> ($stable(drActive) && $stable(irActive))); // R7

  AST_NEXT_MATCH: assert property (@(posedge tck) disable iff (!trstN)
    1'b1 |=> (curState == $past(nxtState))); // R8

  AST_DR_ENTRY: assert property (@(posedge tck) disable iff (!trstN)
    (curState == 4'd2 && !tmsIn) |=> (curState == 4'd3 && drActive)); // R3

  AST_IR_ABORT: assert property (@(posedge tck) disable iff (!trstN)
    (curState == 4'd9 && tmsIn) |=> (curState == 4'd0)); // R4

  AST_UPDATE_EXIT: assert property (@(posedge tck) disable iff (!trstN)
    (curState == 4'd8 && tmsIn) |=> (curState == 4'd2)); // R6

endmodule

bind tap_sequencer tap_sequencer_chk i_chk (
  .tck      (tck),
  .trstN    (trstN),
  .tmsIn    (tmsIn),
  .curState (curState),
  .nxtState (nxtState),
  .drActive (drActive),
  .irActive (irActive)
);

// File: tb/test_tap_sequencer.sv
`timescale 1ns/1ps
module test_tap_sequencer;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tmsIn = 1'b1;
  logic [3:0] curState, nxtState;
  logic drActive, irActive, inReset, drCapture, drShift, drUpdate;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference
  int mState = 0;
  bit mDr = 0, mIr = 0;

  always #5 tck = ~tck;

  tap_sequencer i_tap_sequencer (
    .tck(tck), .trstN(trstN), .tmsIn(tmsIn),
    .curState(curState), .nxtState(nxtState),
    .drActive(drActive), .irActive(irActive), .inReset(inReset),
    .drCapture(drCapture), .drShift(drShift), .drUpdate(drUpdate)
  );

  function automatic int refNext(int s, bit t);
    case (s)
      0: return t ? 0 : 1;
      1: return t ? 2 : 1;
      2: return t ? 9 : 3;
      9: return t ? 0 : 3;
      3: return t ? 5 : 4;
      4: return t ? 5 : 4;
      5: return t ? 8 : 6;
      6: return t ? 7 : 6;
      7: return t ? 8 : 4;
      8: return t ? 2 : 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "curState", int'(curState), mState);
    chk("R7", "drActive", int'(drActive), int'(mDr));
    chk("R7", "irActive", int'(irActive), int'(mIr));
    chk("R9", "inReset", int'(inReset), int'(mState == 0));
    chk("R9", "drCapture", int'(drCapture), int'(mDr && mState == 3));
    chk("R9", "drShift", int'(drShift), int'(mDr && mState == 4));
    chk("R9", "drUpdate", int'(drUpdate), int'(mDr && mState == 8));
  endtask

  // drive tms at negedge, check nxtState, clock once, compare after edge
  task automatic step(bit t, string tag);
    tmsIn = t;
    #1;
    chk("R8", "nxtState", int'(nxtState), refNext(mState, t));
    @(posedge tck);
    if (mState == 2 && !t) begin mDr = 1; mIr = 0; end
    else if (mState == 9 && !t) begin mDr = 0; mIr = 1; end
    else if (mState == 8) begin mDr = 0; mIr = 0; end
    mState = refNext(mState, t);
    @(negedge tck);
    compareAll(tag);
  endtask

  task automatic steps(logic [7:0] bits, int n, string tag);
    for (int i = 0; i < n; i++) step(bits[i], tag);
  endtask

  task automatic applyReset();
    @(negedge tck);
    #2 trstN = 1'b0;
    #1;
    mState = 0; mDr = 0; mIr = 0;
    compareAll("R1");
    @(negedge tck);
    trstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tmsIn = 1'b1;
    #1;
    compareAll("R1");
    repeat (2) @(negedge tck);
    trstN = 1'b1;
    // R2: reset hold and idle loop
    step(1, "R2"); step(0, "R2"); step(0, "R2"); step(1, "R2");
    // R3 DR entry, R5 phase loops, R6 update to idle
    step(0, "R3"); step(0, "R5"); step(0, "R5"); step(1, "R5");
    step(0, "R5"); step(0, "R5"); step(1, "R5"); step(0, "R5");
    step(1, "R5"); step(1, "R5"); step(0, "R6");
    // R4 IR entry, update to select-DR
    step(1, "R2"); step(1, "R3"); step(0, "R4"); step(1, "R5");
    step(1, "R5"); step(1, "R6");
    // straight from IR update into DR scan
    step(0, "R3"); step(0, "R5"); step(1, "R5"); step(1, "R6");
    step(1, "R3"); step(1, "R4");
    // R1: async reset mid-scan between edges
    step(0, "R2"); step(1, "R2"); step(0, "R3"); step(0, "R5");
    applyReset();
    // R10: five tms-high edges from each of the ten states
    for (int s = 0; s < 10; s++) begin
      for (int br = 0; br < 2; br++) begin
        applyReset();
        case (s)
          1: steps(8'b0, 1, "R2");
          2: steps(8'b10, 2, "R2");
          9: steps(8'b110, 3, "R3");
          3: steps(br ? 8'b0110 : 8'b010, br ? 4 : 3, "R5");
          4: steps(br ? 8'b00110 : 8'b0010, br ? 5 : 4, "R5");
          5: steps(br ? 8'b10110 : 8'b1010, br ? 5 : 4, "R5");
          6: steps(br ? 8'b010110 : 8'b01010, br ? 6 : 5, "R5");
          7: steps(br ? 8'b1010110 : 8'b101010, br ? 7 : 6, "R5");
          8: steps(br ? 8'b110110 : 8'b11010, br ? 6 : 5, "R6");
          default: ;
        endcase
        chk("R10", "start state", int'(curState), s);
        for (int k = 0; k < 5; k++) step(1, "R10");
        chk("R10", "final state", int'(curState), 0);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule